// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block lets a host with a 32-bit register window reach the registers of a slow subsystem that has only an 8-bit register bus. Six words are decoded in the window. Three of them drive the indirect path: a command word, a low data word and a high data word. Two more hold the interrupt enables and flags of the bridge. The last is a constant identification word.

Software first programs the command word with the target address, the direction and the byte-lane enables. For a write, it then puts the data in the low data word, and that write launches the slow-side cycle. For a read, the command write alone launches the cycle. The returned byte is placed in the low data word once the busy bit clears.

The slow side is modelled as a fixed-latency handshake. The select line stays high for `LATENCY` cycles. On the last of those cycles, a strobe marks the point where the subsystem commits a write or where the bridge samples read data.

Top module: `bb_bridge`

## Requirements
- R1: After reset, the command word reads 0 (busy clear), both data words read 0, the enable and flag words read 0, `irq` is 0, and word index 0 (byte offset 0x00) reads the constant `ID_VALUE`.
- R2: A write to the command word (offset 0x04) while idle stores the direction in bit 24 (1 = read), the low-word byte enables in bits 19:16, the high-word byte enables in bits 23:20 and the target address in bits 7:0, and all of these read back unchanged. Bit 31 reads as the busy flag.
- R3: When the stored direction is write, at least one low enable is set and the bridge is idle, a write to the low data word (offset 0x08) starts one slow-side write. That write carries the stored address, `sb_we`=1, and the data byte from the lowest-numbered enabled lane of the low data word. A low data write while the direction is read only stores the data.
- R4: A command write while idle that has bit 24 set and a nonzero bits 19:16 starts one slow-side read. When busy clears, the low data word holds the returned byte in the lowest-numbered enabled low lane and zero in the other three lanes.
- R5: Busy (command bit 31, and `sb_sel`) rises in the cycle after the starting write and stays high for exactly `LATENCY` cycles. `sb_strobe` is high only in the last of those cycles.
- R6: While busy is set, writes to the command, low data and high data words are ignored and do not start a transfer.
- R7: A command word or low data write that would start a transfer while all four low enables are clear starts nothing: busy stays 0 and no strobe occurs.
- R8: The high data word (offset 0x0C) is plain read/write storage, and the high enables take no part in the slow-side cycle.
- R9: In the flag word (offset 0x14), bit 0 is set when a transfer completes and bit 1 is set by a one-cycle `sub_irq` pulse. Writing 1 to a bit clears it, writing 0 leaves it, and a set in the same cycle as a clear wins.
- R10: The enable word (offset 0x10) holds bits 1:0 with the same bit meaning as the flag word, and `irq` is high exactly when some flag bit and its enable bit are both 1.
- R11: Writes to the identification word and to undecoded offsets change no state, and reads of undecoded offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 6 | Host byte address within the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| sb_sel | output | 1 | Slow-side cycle in progress |
| sb_we | output | 1 | Slow-side cycle is a write |
| sb_addr | output | SB_AW | Slow-side register address |
| sb_wdata | output | 8 | Slow-side write byte |
| sb_strobe | output | 1 | Last cycle of the slow-side cycle: commit or sample |
| sb_rdata | input | 8 | Slow-side read byte, sampled on `sb_strobe` |
| sub_irq | input | 1 | Subsystem interrupt pulse |
| irq | output | 1 | Masked interrupt output |

## Verification
Transfers are driven with several byte-enable patterns: only lane 0, only a high lane, several lanes at once and no lanes at all. These patterns separate correct lowest-lane selection from a fixed lane, and from a bridge that starts on an empty mask. Reads and writes go to different addresses, and the slow-side model returns a byte derived from the address, so a swapped direction or a stale address shows up in the data. Writes issued right after a launch, while busy is still set, expose any bridge that lets busy accesses through. A flag clear placed in the same cycle as an interrupt pulse separates set-priority from clear-priority.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam logic [3:0] WIX_ID    = 4'd0;
  localparam logic [3:0] WIX_CMD   = 4'd1;
  localparam logic [3:0] WIX_LDATA = 4'd2;
  localparam logic [3:0] WIX_UDATA = 4'd3;
  localparam logic [3:0] WIX_IEN   = 4'd4;
  localparam logic [3:0] WIX_IFLG  = 4'd5;

  localparam int CMD_BUSY_BIT = 31;
  localparam int CMD_DIR_BIT  = 24;
  localparam int CMD_LBE_LSB  = 16;
  localparam int CMD_UBE_LSB  = 20;
  localparam int LANES        = 4;
  localparam int IRQ_BITS     = 2;
endpackage

// File: rtl/bb_lane_pick.sv
module bb_lane_pick #(
  parameter int NLANE = 4,
  localparam int IW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic [NLANE-1:0] lane_en,
  output logic [NLANE-1:0] lane_sel,
  output logic [IW-1:0]    lane_idx,
  output logic             lane_any
);
  logic [NLANE:0] seen;

  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NLANE; gi++) begin : g_lane
      assign seen[gi+1]   = seen[gi] | lane_en[gi];
      assign lane_sel[gi] = lane_en[gi] & ~seen[gi];
    end
  endgenerate

  assign lane_any = seen[NLANE];

  always_comb begin
    lane_idx = '0;
    for (int i = NLANE - 1; i >= 0; i--) begin
      if (lane_en[i]) lane_idx = IW'(i);
    end
  end
endmodule

// File: rtl/bb_xfer_seq.sv
module bb_xfer_seq #(
  parameter int LATENCY = 6,
  localparam int CW = $clog2(LATENCY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic strobe
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = start | busy_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LATENCY - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy   = busy_q;
  assign strobe = busy_q && (cnt_q == '0);

  a_r6_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
  a_r5_fall_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(strobe));
endmodule

// File: rtl/bb_irq_regs.sv
module bb_irq_regs #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_we,
  input  logic          flg_we,
  input  logic [NB-1:0] wbits,
  input  logic [NB-1:0] set_vec,
  output logic [NB-1:0] en_q,
  output logic [NB-1:0] flg_q,
  output logic          irq
);
  logic [NB-1:0] en_d, flg_d;
  logic          flg_ce;

  always_comb begin
    en_d   = en_we ? wbits : en_q;
    flg_ce = flg_we | (|set_vec);
    flg_d  = flg_q;
    if (flg_we) flg_d = flg_d & ~wbits;
    flg_d  = flg_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      flg_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (flg_ce) flg_q <= flg_d;
    end
  end

  assign irq = |(flg_q & en_q);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_vec[NB-1]) |-> flg_q[NB-1]);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flg_q[0]) && !$past(flg_we)) |-> flg_q[0]);
endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
  import bb_pkg::*;
#(
  parameter int          SB_AW    = 8,
  parameter int          LATENCY  = 6,
  parameter logic [31:0] ID_VALUE = 32'h5B1D_0A01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [5:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             sb_sel,
  output logic             sb_we,
  output logic [SB_AW-1:0] sb_addr,
  output logic [7:0]       sb_wdata,
  output logic             sb_strobe,
  input  logic [7:0]       sb_rdata,
  input  logic             sub_irq,
  output logic             irq
);
  localparam int LIW = $clog2(LANES);

  logic [3:0]       widx;
  logic             busy;
  logic             dir_q, dir_d;
  logic [LANES-1:0] lbe_q, lbe_d, ube_q, ube_d;
  logic [SB_AW-1:0] tadr_q, tadr_d;
  logic [31:0]      ldat_q, ldat_d, udat_q, udat_d;
  logic             cmd_ce, ldat_ce, udat_ce;
  logic             wr_cmd, wr_ldat, wr_udat, wr_ien, wr_iflg;
  logic             start;
  logic [LANES-1:0] lane_sel;
  logic [LIW-1:0]   lane_idx;
  logic             lane_any;
  logic [31:0]      rd_fill;
  logic [IRQ_BITS-1:0] ien_q, iflg_q, irq_set;
  logic             done;

  assign widx    = host_addr[5:2];
  assign wr_cmd  = host_we && widx == WIX_CMD   && !busy;
  assign wr_ldat = host_we && widx == WIX_LDATA && !busy;
  assign wr_udat = host_we && widx == WIX_UDATA && !busy;
  assign wr_ien  = host_we && widx == WIX_IEN;
  assign wr_iflg = host_we && widx == WIX_IFLG;

  bb_lane_pick #(.NLANE(LANES)) u_pick (
    .lane_en  (lbe_q),
    .lane_sel (lane_sel),
    .lane_idx (lane_idx),
    .lane_any (lane_any)
  );

  // launch: read on command write, write on low-data write
  assign start = (wr_cmd && host_wdata[CMD_DIR_BIT]
                  && |host_wdata[CMD_LBE_LSB +: LANES])
               || (wr_ldat && !dir_q && lane_any);

  bb_xfer_seq #(.LATENCY(LATENCY)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .strobe (sb_strobe)
  );

  assign done = sb_strobe;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_fill
      assign rd_fill[8*gl +: 8] = lane_sel[gl] ? sb_rdata : 8'h00;
    end
  endgenerate

  always_comb begin
    dir_d   = dir_q;
    lbe_d   = lbe_q;
    ube_d   = ube_q;
    tadr_d  = tadr_q;
    ldat_d  = ldat_q;
    udat_d  = udat_q;
    cmd_ce  = wr_cmd;
    ldat_ce = wr_ldat | (done & dir_q);
    udat_ce = wr_udat;
    if (wr_cmd) begin
      dir_d  = host_wdata[CMD_DIR_BIT];
      lbe_d  = host_wdata[CMD_LBE_LSB +: LANES];
      ube_d  = host_wdata[CMD_UBE_LSB +: LANES];
      tadr_d = host_wdata[SB_AW-1:0];
    end
    if (wr_ldat)            ldat_d = host_wdata;
    else if (done && dir_q) ldat_d = rd_fill;
    if (wr_udat)            udat_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      lbe_q  <= '0;
      ube_q  <= '0;
      tadr_q <= '0;
    end else if (cmd_ce) begin
      dir_q  <= dir_d;
      lbe_q  <= lbe_d;
      ube_q  <= ube_d;
      tadr_q <= tadr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldat_q <= '0;
    else if (ldat_ce) ldat_q <= ldat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) udat_q <= '0;
    else if (udat_ce) udat_q <= udat_d;
  end

  assign irq_set = {sub_irq, done};

  bb_irq_regs #(.NB(IRQ_BITS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_we   (wr_ien),
    .flg_we  (wr_iflg),
    .wbits   (host_wdata[IRQ_BITS-1:0]),
    .set_vec (irq_set),
    .en_q    (ien_q),
    .flg_q   (iflg_q),
    .irq     (irq)
  );

  assign sb_sel   = busy;
  assign sb_we    = !dir_q;
  assign sb_addr  = tadr_q;
  assign sb_wdata = ldat_q[8*lane_idx +: 8];

  always_comb begin
    host_rdata = '0;
    case (widx)
      WIX_ID:    host_rdata = ID_VALUE;
      WIX_CMD: begin
        host_rdata[CMD_BUSY_BIT]                = busy;
        host_rdata[CMD_DIR_BIT]                 = dir_q;
        host_rdata[CMD_UBE_LSB +: LANES]        = ube_q;
        host_rdata[CMD_LBE_LSB +: LANES]        = lbe_q;
        host_rdata[SB_AW-1:0]                   = tadr_q;
      end
      WIX_LDATA: host_rdata = ldat_q;
      WIX_UDATA: host_rdata = udat_q;
      WIX_IEN:   host_rdata[IRQ_BITS-1:0] = ien_q;
      WIX_IFLG:  host_rdata[IRQ_BITS-1:0] = iflg_q;
      default:   host_rdata = '0;
    endcase
  end

  a_r6_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(tadr_q) && $stable(dir_q) && $stable(lbe_q)));
  a_r3_wdata_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sb_wdata));
  a_r7_launch_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lane_any);
  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> iflg_q[0]);
  a_r5_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sb_strobe |-> sb_sel);
endmodule

// File: tb/bb_bridge_bench.sv
module bb_bridge_bench;
  localparam int          LAT = 6;
  localparam logic [31:0] IDV = 32'h5B1D_0A01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        sb_sel, sb_we, sb_strobe, irq;
  logic [7:0]  sb_addr, sb_wdata, sb_rdata;
  logic        sub_irq = 1'b0;

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  logic [7:0] last_addr, last_data;
  logic       last_we;

  always #4 clk = ~clk;

  assign sb_rdata = sb_addr ^ 8'h3C;

  bb_bridge #(.SB_AW(8), .LATENCY(LAT), .ID_VALUE(IDV)) u_bb_bridge (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .sb_sel, .sb_we, .sb_addr, .sb_wdata, .sb_strobe, .sb_rdata,
    .sub_irq, .irq
  );

  always @(posedge clk) begin
    if (sb_strobe) begin
      strobes   <= strobes + 1;
      last_addr <= sb_addr;
      last_data <= sb_wdata;
      last_we   <= sb_we;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (host_rdata[31] === 1'b1 || sb_sel === 1'b1) begin
      n++;
      @(negedge clk);
      host_addr = 6'h04;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hread(6'h00, v); check("R1 id", v, IDV);
    hread(6'h04, v); check("R1 cmd", v, 32'h0);
    hread(6'h08, v); check("R1 ldata", v, 32'h0);
    hread(6'h10, v); check("R1 ien", v, 32'h0);
    hread(6'h14, v); check("R1 iflg", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_cmd_readback();
    logic [31:0] v;
    hwrite(6'h04, 32'h00A0_0057);
    hread(6'h04, v); check("R2 cmd readback", v, 32'h00A0_0057);
    check("R7 no launch without low lanes", {31'b0, sb_sel}, 32'h0);
  endtask

  task automatic t_write_xfer();
    int n, s0;
    s0 = strobes;
    hwrite(6'h04, 32'h000C_0042);
    hwrite(6'h08, 32'h11AA_BB22);
    host_addr = 6'h04;
    #1 check("R5 busy bit", {31'b0, host_rdata[31]}, 32'h1);
    wait_idle(n);
    check("R5 busy length", n, LAT);
    check("R3 one strobe", strobes - s0, 1);
    check("R3 addr", {24'b0, last_addr}, 32'h42);
    check("R3 lowest lane byte", {24'b0, last_data}, 32'hAA);
    check("R3 write dir", {31'b0, last_we}, 32'h1);
  endtask

  task automatic t_read_xfer();
    logic [31:0] v;
    int n;
    hwrite(6'h04, 32'h0104_0019);
    wait_idle(n);
    check("R5 read busy length", n, LAT);
    hread(6'h08, v); check("R4 lane2 placement", v, {8'h00, 8'h19 ^ 8'h3C, 16'h0000});
    hwrite(6'h08, 32'h7777_7777);
    hread(6'h08, v); check("R3 ldata store in read dir", v, 32'h7777_7777);
    check("R3 no launch in read dir", {31'b0, sb_sel}, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int n, s0;
    hwrite(6'h04, 32'h0001_0033);
    s0 = strobes;
    hwrite(6'h08, 32'h0000_00C5);
    hwrite(6'h04, 32'h010F_0099);
    hwrite(6'h08, 32'h0000_00EE);
    hwrite(6'h0C, 32'hDEAD_0001);
    wait_idle(n);
    check("R6 single strobe", strobes - s0, 1);
    check("R6 data kept", {24'b0, last_data}, 32'hC5);
    hread(6'h04, v); check("R6 cmd kept", v, 32'h0001_0033);
    hread(6'h08, v); check("R6 ldata kept", v, 32'h0000_00C5);
    hread(6'h0C, v); check("R6 udata kept", v, 32'h0);
  endtask

  task automatic t_no_enable();
    int s0;
    s0 = strobes;
    hwrite(6'h04, 32'h01F0_0010);
    repeat (LAT + 2) @(negedge clk);
    check("R7 read no lanes", strobes - s0, 0);
    hwrite(6'h04, 32'h00F0_0010);
    hwrite(6'h08, 32'h1234_5678);
    repeat (LAT + 2) @(negedge clk);
    check("R7 write no lanes", strobes - s0, 0);
  endtask

  task automatic t_udata();
    logic [31:0] v;
    int n, s0;
    hwrite(6'h0C, 32'hCAFE_F00D);
    hread(6'h0C, v); check("R8 udata store", v, 32'hCAFE_F00D);
    s0 = strobes;
    hwrite(6'h04, 32'h00F8_0021);
    hwrite(6'h08, 32'h5500_0000);
    wait_idle(n);
    check("R8 upper lanes ignored", {24'b0, last_data}, 32'h55);
    check("R8 strobe count", strobes - s0, 1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    hwrite(6'h14, 32'h3);
    hread(6'h14, v); check("R9 w1c both", v, 32'h0);
    hwrite(6'h04, 32'h0101_0001);
    repeat (LAT + 2) @(negedge clk);
    hread(6'h14, v); check("R9 done flag", v, 32'h1);
    check("R10 masked", {31'b0, irq}, 32'h0);
    hwrite(6'h10, 32'h1);
    check("R10 enabled", {31'b0, irq}, 32'h1);
    hwrite(6'h14, 32'h2);
    hread(6'h14, v); check("R9 write0 keeps", v, 32'h1);
    hwrite(6'h14, 32'h1);
    check("R10 cleared", {31'b0, irq}, 32'h0);
    @(negedge clk); sub_irq = 1'b1;
    @(negedge clk); sub_irq = 1'b0;
    hread(6'h14, v); check("R9 sub flag", v, 32'h2);
    check("R10 bit1 masked", {31'b0, irq}, 32'h0);
    hwrite(6'h10, 32'h2);
    check("R10 bit1 enabled", {31'b0, irq}, 32'h1);
    @(negedge clk);
    host_we = 1'b1; host_addr = 6'h14; host_wdata = 32'h2; sub_irq = 1'b1;
    @(negedge clk);
    host_we = 1'b0; sub_irq = 1'b0;
    hread(6'h14, v); check("R9 set wins", v, 32'h2);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    hwrite(6'h00, 32'hFFFF_FFFF);
    hread(6'h00, v); check("R11 id ro", v, IDV);
    hwrite(6'h18, 32'hFFFF_FFFF);
    hwrite(6'h3C, 32'hFFFF_FFFF);
    hread(6'h18, v); check("R11 unmapped read", v, 32'h0);
    hread(6'h3C, v); check("R11 unmapped read hi", v, 32'h0);
    hread(6'h10, v); check("R11 ien untouched", v, 32'h2);
    check("R11 no launch", {31'b0, sb_sel}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_readback();
    t_write_xfer();
    t_read_xfer();
    t_busy_ignore();
    t_no_enable();
    t_udata();
    t_irq();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule